// File: doc/BRIEF.md
# Dual-Edge Half-Period Interval Counter

This block measures how long an asynchronous gate signal stays high. The unit is half a clock period. It does this without a faster clock. Two counters share one clock. One advances on rising edges and the other on falling edges, and each has its own synchronizer for the gate. Their values are added, so the total counts every clock edge (of either polarity) at which the gate was seen high. With a 200 MHz clock this gives 2.5 ns steps.

When the synchronized gate closes, a short settle pipeline waits for the falling-edge count to be retimed and summed. The block then latches the total and pulses a strobe for one cycle. The counts are not restarted by a new gate. Successive gates accumulate until `clear_i` is pulsed.

Usage constraints:
- Each gate pulse must cover at least one rising clock edge.
- Successive gate pulses must be separated by at least SYNC_STAGES+4 cycles.
- `clear_i` is applied while the gate is low.

Top module: `dual_edge_interval_counter`

## Requirements
- R1: `result_o` equals the number of rising clock edges plus the number of falling clock edges, since the last clear, at which `gate_i` was high.
- R2: A gate held for exactly N clock periods and aligned to the clock reports 2N. Delaying only its closing by half a period reports 2N+1. Delaying only its opening by half a period reports 2N-1.
- R3: Each edge count saturates at 2^CNT_W-1 and never wraps. `result_o` is CNT_W+1 bits wide and tops out at 2*(2^CNT_W-1).
- R4: `valid_o` is a single-cycle pulse. It rises at the (SYNC_STAGES+3)-th rising edge after the last rising edge at which `gate_i` was high. That is the 5th rising edge with the default of 2.
- R5: `result_o` changes only in a cycle in which `valid_o` is high. Otherwise it holds its last value.
- R6: Without a clear, a second gate adds to the counts of the first.
- R7: `clear_i`, sampled high at a rising edge and held for a full cycle, zeroes both counts. The next measurement then starts from zero.
- R8: A clear sampled at the same rising edge that raises `valid_o` does not alter the value reported by that pulse.
- R9: While reset is active, `valid_o` is 0 and `result_o` is 0. Reset is asserted asynchronously (active low) and released on a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Measurement clock; both edges are used |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Asynchronous gate whose high time is measured |
| clear_i | input | 1 | Synchronous clear of both edge counts |
| result_o | output | CNT_W+1 | Latched interval, in half-period units |
| valid_o | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The two functions that can fall in the same cycle are the clear of the counters and the latching of the finished sum.

The bench provokes this by raising `clear_i` so that it is sampled at exactly the rising edge that produces the `valid_o` pulse. The falling-edge counter therefore sees the clear half a cycle earlier.

It is judged by two checks:
- The pulse must still carry the full pre-clear total.
- The next gate must report only its own edges.

A behavioural edge-counting model decides both expectations every cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } ivc_edge_e;

  // Cycles between the gate closing in the rising domain and the latch.
  localparam int unsigned SETTLE_CYCLES = 3;

endpackage

// File: rtl/ivc_gate_sync.sv
module ivc_gate_sync #(
  parameter int unsigned        STAGES = 2,
  parameter ivc_pkg::ivc_edge_e EDGE   = ivc_pkg::EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  if (EDGE == ivc_pkg::EDGE_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ivc_edge_counter.sv
module ivc_edge_counter #(
  parameter int unsigned        CNT_W = 16,
  parameter ivc_pkg::ivc_edge_e EDGE  = ivc_pkg::EDGE_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  always_comb begin
    step  = en_i && (cnt_q != CNT_MAX);
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  if (EDGE == ivc_pkg::EDGE_FALL) begin : g_fall
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end

    p_no_overflow_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
    p_idle_hold_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!clr_i && !en_i) |=> $stable(cnt_q));
    p_clear_zero_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
  end else begin : g_rise
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
    p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !en_i) |=> $stable(cnt_q));
    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ivc_collect.sv
module ivc_collect #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_rise_i,
  input  logic [CNT_W-1:0] cnt_rise_i,
  input  logic [CNT_W-1:0] cnt_fall_i,
  output logic [CNT_W:0]   result_o,
  output logic             valid_o
);

  localparam int unsigned PIPE = ivc_pkg::SETTLE_CYCLES - 1;

  logic [CNT_W-1:0] fall_rt_q;
  logic [CNT_W:0]   sum_q,    sum_d;
  logic             gate_d_q;
  logic             close_det;
  logic [PIPE-1:0]  pipe_q,   pipe_d;
  logic [CNT_W:0]   result_q, result_d;
  logic             valid_q,  valid_d;
  logic             latch_en;

  always_comb begin
    close_det = gate_d_q && !gate_rise_i;
    sum_d     = {1'b0, cnt_rise_i} + {1'b0, fall_rt_q};
    pipe_d    = {pipe_q[PIPE-2:0], close_det};
    latch_en  = pipe_q[PIPE-1];
    valid_d   = latch_en;
    result_d  = latch_en ? sum_q : result_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_rt_q <= '0;
      sum_q     <= '0;
      gate_d_q  <= 1'b0;
      pipe_q    <= '0;
      result_q  <= '0;
      valid_q   <= 1'b0;
    end else begin
      fall_rt_q <= cnt_fall_i;
      sum_q     <= sum_d;
      gate_d_q  <= gate_rise_i;
      pipe_q    <= pipe_d;
      result_q  <= result_d;
      valid_q   <= valid_d;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;

  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |=> (valid_q || $stable(result_q)));
  p_sum_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q <= {1'b0, {CNT_W{1'b1}}} + {1'b0, {CNT_W{1'b1}}});

endmodule

// File: rtl/dual_edge_interval_counter.sv
module dual_edge_interval_counter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gate_i,
  input  logic           clear_i,
  output logic [CNT_W:0] result_o,
  output logic           valid_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [1:0]       gate_s;
  logic [CNT_W-1:0] cnt [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  for (genvar e = 0; e < 2; e++) begin : g_edge
    localparam ivc_pkg::ivc_edge_e DOM =
      (e == 0) ? ivc_pkg::EDGE_RISE : ivc_pkg::EDGE_FALL;

    ivc_gate_sync #(
      .STAGES (SYNC_STAGES),
      .EDGE   (DOM)
    ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .async_i (gate_i),
      .sync_o  (gate_s[e])
    );

    ivc_edge_counter #(
      .CNT_W (CNT_W),
      .EDGE  (DOM)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .clr_i  (clear_i),
      .en_i   (gate_s[e]),
      .cnt_o  (cnt[e])
    );
  end

  ivc_collect #(
    .CNT_W (CNT_W)
  ) u_collect (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .gate_rise_i (gate_s[0]),
    .cnt_rise_i  (cnt[0]),
    .cnt_fall_i  (cnt[1]),
    .result_o    (result_o),
    .valid_o     (valid_o)
  );

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_n_int |-> (!valid_o && result_o == '0));

endmodule

// File: tb/sim_dual_edge_interval_counter.sv
module sim_dual_edge_interval_counter;

  localparam int CW   = 6;
  localparam int MAXC = (1 << CW) - 1;
  localparam int LAT  = 5;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate  = 1'b0;
  logic          clear = 1'b0;
  logic [CW:0]   result;
  logic          valid;

  int    errors   = 0;
  int    checks   = 0;
  bit    chk_en   = 0;
  bit    finished = 0;
  int    pos_hits = 0;
  int    neg_hits = 0;
  int    since    = 0;
  bit    armed    = 0;
  bit    exp_valid = 0;
  int    exp_res  = 0;
  int    last_res = 0;
  string cur_req  = "R1";

  always #10 clk = ~clk;

  dual_edge_interval_counter #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .gate_i   (gate),
    .clear_i  (clear),
    .result_o (result),
    .valid_o  (valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: count gate samples at each clock edge.
  always @(negedge clk) if (gate) neg_hits++;

  always @(posedge clk) begin
    exp_valid = 1'b0;
    if (gate) begin
      armed = 1'b1;
      since = 0;
      pos_hits++;
    end else if (armed) begin
      since++;
      if (since == LAT) begin
        exp_valid = 1'b1;
        armed     = 1'b0;
        exp_res   = ((pos_hits > MAXC) ? MAXC : pos_hits) +
                    ((neg_hits > MAXC) ? MAXC : neg_hits);
      end
    end
    if (clear) begin
      pos_hits = 0;
      neg_hits = 0;
    end
    #3;
    if (chk_en) begin
      check(valid == exp_valid, "R4", int'(valid), int'(exp_valid));
      if (exp_valid) begin
        check(int'(result) == exp_res, cur_req, int'(result), exp_res);
        last_res = exp_res;
      end else begin
        check(int'(result) == last_res, "R5", int'(result), last_res);
      end
    end
  end

  task automatic pulse(input int cyc, input bit late_rise, input bit late_fall,
                       input bit clr_at_valid);
    @(posedge clk);
    #(late_rise ? 16 : 6) gate = 1'b1;
    repeat (cyc) @(posedge clk);
    #(late_fall ? 16 : 6) gate = 1'b0;
    if (clr_at_valid) begin
      repeat (4) @(posedge clk);
      #6 clear = 1'b1;
      @(posedge clk);
      #6 clear = 1'b0;
      repeat (8) @(posedge clk);
    end else begin
      repeat (10) @(posedge clk);
    end
  endtask

  task automatic do_clear();
    @(posedge clk);
    #6 clear = 1'b1;
    @(posedge clk);
    #6 clear = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #6;
    check(valid == 1'b0, "R9", int'(valid), 0);
    check(result == '0, "R9", int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #6 chk_en = 1'b1;
    check(result == '0, "R9", int'(result), 0);

    cur_req = "R2"; pulse(3, 0, 0, 0);      // 2N = 6
    do_clear();
    cur_req = "R2"; pulse(3, 0, 1, 0);      // 2N+1 = 7
    do_clear();
    cur_req = "R2"; pulse(3, 1, 0, 0);      // 2N-1 = 5
    do_clear();
    cur_req = "R1"; pulse(1, 0, 0, 0);      // 2
    cur_req = "R6"; pulse(2, 0, 0, 0);      // accumulated 6
    cur_req = "R8"; pulse(2, 1, 1, 1);      // 6 + 4, clear lands on valid cycle
    cur_req = "R7"; pulse(2, 0, 0, 0);      // restarts at 0 -> 4
    do_clear();
    cur_req = "R1"; pulse(4, 1, 1, 0);      // 8
    do_clear();
    cur_req = "R3"; pulse(70, 0, 0, 0);     // saturated 126
    cur_req = "R3"; pulse(5, 0, 1, 0);      // stays 126
    do_clear();
    cur_req = "R7"; pulse(1, 0, 1, 0);      // 3

    finished = 1'b1;
    repeat (2) @(posedge clk);
    #8;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule